// File: doc/BRIEF.md
# Extended-capabilities parallel port host handshake engine

This block is the host end of a byte-wide extended-capabilities parallel link. In the forward direction it takes bytes from a ready/valid stream, places each on the port data bus and runs a fully interlocked four-edge exchange with the peripheral's acknowledge line. In the reverse direction it releases the bus and collects bytes from the peripheral with a matching interlock on its own acknowledge output. Each received byte is presented on a second ready/valid stream.

The system side selects the link direction with a level request. The engine applies that request only when no byte is in flight. Every port input passes through a synchronizer before the state machine sees it. While the link runs forward, a low level on the peripheral's reversal-request line is reported as a flag. Any handshake edge that fails to arrive within a bounded number of cycles ends the exchange, releases the lines to idle, and sets an error flag that stays set until reset.

Top module: `ecp_host_ctrl`

## Requirements
- R1: After reset the engine is forward idle. `host_clk_n` and `host_ack` are high, `pd_oe` is high, and `rx_valid`, `periph_req` and `timeout_err` are low.
- R2: In forward idle, `tx_ready` is high only when the synchronized `periph_ack` is low and `rev_req` is low. A pending `rev_req` takes priority over a waiting `tx_valid`, and no byte is sent while `periph_ack` is high.
- R3: An accepted byte appears on `pd_out` exactly `SETUP_CYC` cycles before `host_clk_n` falls. It stays unchanged while `host_clk_n` is low.
- R4: `host_clk_n` returns high only after `periph_ack` has been seen high, unless the handshake is aborted by the timeout.
- R5: A forward transfer is complete, and `tx_ready` can rise again, only once `periph_ack` has returned low after `host_clk_n` rose.
- R6: `periph_req` is the synchronized inverse of `periph_req_n` while the link is forward. It is held low in the reverse direction.
- R7: The direction changes only from an idle state. `pd_oe` is low throughout the reverse direction and high throughout the forward direction. A direction request made in the middle of a reverse byte takes effect only after that byte completes.
- R8: In reverse, `host_ack` idles low. It is raised only after `periph_clk` has been seen low while the receive slot (`rx_valid`) is empty.
- R9: When `periph_clk` rises during a reverse byte, the engine captures `pd_in` into `rx_data`, asserts `rx_valid` and drives `host_ack` low again. `rx_valid` and `rx_data` hold until `rx_ready` is seen.
- R10: If any handshake wait lasts `TIMEOUT_CYC` cycles, the engine returns to the idle state of the current direction and releases its strobe or acknowledge line. It also sets `timeout_err`, which stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_data | input | DW | Byte to send forward |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Transmit byte taken this cycle |
| rx_data | output | DW | Byte received from the peripheral |
| rx_valid | output | 1 | Received byte held for the system |
| rx_ready | input | 1 | System takes the received byte |
| rev_req | input | 1 | 1 requests reverse direction, 0 forward |
| periph_req | output | 1 | Peripheral asks for reversal (forward only) |
| timeout_err | output | 1 | Sticky handshake timeout flag |
| host_clk_n | output | 1 | Host strobe, active low |
| host_ack | output | 1 | Host acknowledge line |
| periph_ack | input | 1 | Peripheral acknowledge (forward) |
| periph_clk | input | 1 | Peripheral strobe (reverse), active low |
| periph_req_n | input | 1 | Peripheral reversal request, active low |
| pd_out | output | DW | Port data driven by the host |
| pd_in | input | DW | Port data as seen at the pins |
| pd_oe | output | 1 | Port data output enable |

## Verification
Two pairs of functions meet in the same cycle, and each needs a rule for who wins. The first pair is a direction request and a pending transmit byte in forward idle. The bench raises `rev_req` and `tx_valid` on the same edge and expects `tx_ready` to stay low, the strobe to stay high and the bus to be released. The second pair is a reversal request from the peripheral and a forward byte already in flight. The bench pulls `periph_req_n` low while that byte is handed over and expects `periph_req` to rise while the four-edge exchange still runs to completion. It then checks that a direction drop in the middle of a reverse byte waits for that byte to finish.

// File: rtl/ecp_host_pkg.sv
package ecp_host_pkg;

  typedef enum logic [2:0] {
    ST_F_IDLE    = 3'd0,
    ST_F_SETUP   = 3'd1,
    ST_F_WAIT_HI = 3'd2,
    ST_F_WAIT_LO = 3'd3,
    ST_R_IDLE    = 3'd4,
    ST_R_WAIT_HI = 3'd5
  } ecp_state_e;

  function automatic logic is_reverse(input ecp_state_e s);
    return (s == ST_R_IDLE) || (s == ST_R_WAIT_HI);
  endfunction

endpackage

// File: rtl/ecp_sync.sv
module ecp_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) pipe[i] <= RST_VAL;
        else if (i == 0) pipe[i] <= d;
        else pipe[i] <= pipe[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/ecp_cycle_cnt.sv
module ecp_cycle_cnt #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic done
);
  localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  assign done = run && (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else if (!done)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ecp_host_ctrl.sv
module ecp_host_ctrl
  import ecp_host_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SETUP_CYC   = 4,
  parameter int TIMEOUT_CYC = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_valid,
  output logic          tx_ready,
  output logic [DW-1:0] rx_data,
  output logic          rx_valid,
  input  logic          rx_ready,
  input  logic          rev_req,
  output logic          periph_req,
  output logic          timeout_err,
  output logic          host_clk_n,
  output logic          host_ack,
  input  logic          periph_ack,
  input  logic          periph_clk,
  input  logic          periph_req_n,
  output logic [DW-1:0] pd_out,
  input  logic [DW-1:0] pd_in,
  output logic          pd_oe
);
  localparam logic [2:0] CTL_IDLE = 3'b110;

  logic [2:0]    ctl_s;
  logic [DW-1:0] pd_s;
  logic          pa_s, pc_s, preq_n_s;

  ecp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(CTL_IDLE)) u_sync_ctl (
    .clk(clk), .rst(rst),
    .d({periph_req_n, periph_clk, periph_ack}),
    .q(ctl_s)
  );

  ecp_sync #(.W(DW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_dat (
    .clk(clk), .rst(rst), .d(pd_in), .q(pd_s)
  );

  assign pa_s     = ctl_s[0];
  assign pc_s     = ctl_s[1];
  assign preq_n_s = ctl_s[2];

  ecp_state_e state_q, state_d;
  logic setup_run, setup_done, tmo_run, tmo_hit;
  logic [DW-1:0] pd_out_q, rx_data_q;
  logic rx_valid_q, host_clk_n_q, host_ack_q, pd_oe_q, err_q, preq_q;

  ecp_cycle_cnt #(.LIMIT(SETUP_CYC)) u_setup_cnt (
    .clk(clk), .rst(rst), .run(setup_run), .done(setup_done)
  );

  ecp_cycle_cnt #(.LIMIT(TIMEOUT_CYC)) u_tmo_cnt (
    .clk(clk), .rst(rst), .run(tmo_run), .done(tmo_hit)
  );

  always_comb begin
    state_d   = state_q;
    setup_run = 1'b0;
    tmo_run   = 1'b0;
    unique case (state_q)
      ST_F_IDLE: begin
        if (rev_req)                 state_d = ST_R_IDLE;
        else if (tx_valid && !pa_s)  state_d = ST_F_SETUP;
      end
      ST_F_SETUP: begin
        setup_run = 1'b1;
        if (setup_done) state_d = ST_F_WAIT_HI;
      end
      ST_F_WAIT_HI: begin
        tmo_run = !pa_s;
        if (pa_s || tmo_hit) state_d = pa_s ? ST_F_WAIT_LO : ST_F_IDLE;
      end
      ST_F_WAIT_LO: begin
        tmo_run = pa_s;
        if (!pa_s || tmo_hit) state_d = ST_F_IDLE;
      end
      ST_R_IDLE: begin
        if (!rev_req && pc_s)            state_d = ST_F_IDLE;
        else if (!pc_s && !rx_valid_q)   state_d = ST_R_WAIT_HI;
      end
      ST_R_WAIT_HI: begin
        tmo_run = !pc_s;
        if (pc_s || tmo_hit) state_d = ST_R_IDLE;
      end
      default: state_d = ST_F_IDLE;
    endcase
  end

  assign tx_ready = (state_q == ST_F_IDLE) && !rev_req && !pa_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_F_IDLE;
      pd_out_q     <= '0;
      rx_data_q    <= '0;
      rx_valid_q   <= 1'b0;
      host_clk_n_q <= 1'b1;
      host_ack_q   <= 1'b1;
      pd_oe_q      <= 1'b1;
      err_q        <= 1'b0;
      preq_q       <= 1'b0;
    end else begin
      state_q      <= state_d;
      host_clk_n_q <= (state_d != ST_F_WAIT_HI);
      host_ack_q   <= (state_d != ST_R_IDLE);
      pd_oe_q      <= !is_reverse(state_d);
      preq_q       <= !is_reverse(state_d) && !preq_n_s;
      if (tmo_hit) err_q <= 1'b1;
      if (state_q == ST_F_IDLE && state_d == ST_F_SETUP) pd_out_q <= tx_data;
      if (state_q == ST_R_WAIT_HI && pc_s) begin
        rx_data_q  <= pd_s;
        rx_valid_q <= 1'b1;
      end else if (rx_ready) begin
        rx_valid_q <= 1'b0;
      end
    end
  end

  assign pd_out      = pd_out_q;
  assign rx_data     = rx_data_q;
  assign rx_valid    = rx_valid_q;
  assign host_clk_n  = host_clk_n_q;
  assign host_ack    = host_ack_q;
  assign pd_oe       = pd_oe_q;
  assign timeout_err = err_q;
  assign periph_req  = preq_q;
endmodule

// File: rtl/ecp_host_ctrl_chk.sv
module ecp_host_ctrl_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic [DW-1:0] tx_data,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [DW-1:0] rx_data,
  input logic          rx_valid,
  input logic          rx_ready,
  input logic          rev_req,
  input logic          periph_req,
  input logic          timeout_err,
  input logic          host_clk_n,
  input logic          host_ack,
  input logic          periph_ack,
  input logic          periph_clk,
  input logic          periph_req_n,
  input logic [DW-1:0] pd_out,
  input logic [DW-1:0] pd_in,
  input logic          pd_oe
);
  AST_TXREADY_FWD_IDLE: assert property (@(posedge clk) disable iff (rst)
    tx_ready |-> (pd_oe && host_clk_n && !rev_req)); // R2

  AST_DATA_STABLE_STROBE: assert property (@(posedge clk) disable iff (rst)
    (!host_clk_n && $past(!host_clk_n)) |-> $stable(pd_out)); // R3

  AST_STROBE_RISE_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
    $rose(host_clk_n) |-> (timeout_err || $past(periph_ack, 3))); // R4

  AST_NO_REQ_IN_REVERSE: assert property (@(posedge clk) disable iff (rst)
    !pd_oe |-> !periph_req); // R6

  AST_REVERSE_STROBE_IDLE: assert property (@(posedge clk) disable iff (rst)
    !pd_oe |-> host_clk_n); // R7

  AST_ACK_RISE_SLOT_EMPTY: assert property (@(posedge clk) disable iff (rst)
    ($rose(host_ack) && !pd_oe) |-> $past(!rx_valid)); // R8

  AST_RX_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data))); // R9

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    timeout_err |=> timeout_err); // R10
endmodule

bind ecp_host_ctrl ecp_host_ctrl_chk #(.DW(DW)) u_chk (.*);

// File: tb/ecp_host_ctrl_tb.sv
module ecp_host_ctrl_tb;
  localparam int DW    = 8;
  localparam int SETUP = 4;
  localparam int TMO   = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [DW-1:0] tx_data = '0;
  logic tx_valid = 1'b0;
  logic tx_ready;
  logic [DW-1:0] rx_data;
  logic rx_valid;
  logic rx_ready = 1'b0;
  logic rev_req = 1'b0;
  logic periph_req, timeout_err, host_clk_n, host_ack, pd_oe;
  logic periph_ack = 1'b0;
  logic periph_clk = 1'b1;
  logic periph_req_n = 1'b1;
  logic [DW-1:0] pd_out;
  logic [DW-1:0] pd_in = '0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  ecp_host_ctrl #(.DW(DW), .SETUP_CYC(SETUP), .TIMEOUT_CYC(TMO), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst(rst), .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready), .rev_req(rev_req),
    .periph_req(periph_req), .timeout_err(timeout_err), .host_clk_n(host_clk_n),
    .host_ack(host_ack), .periph_ack(periph_ack), .periph_clk(periph_clk),
    .periph_req_n(periph_req_n), .pd_out(pd_out), .pd_in(pd_in), .pd_oe(pd_oe)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wait_level(ref logic sig, input logic lvl, input int lim, output int n);
    n = 0;
    while (sig !== lvl && n < lim) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic t_reset();
    chk(host_clk_n === 1'b1 && host_ack === 1'b1 && pd_oe === 1'b1, "R1 lines", 0, 1);
    chk(rx_valid === 1'b0 && periph_req === 1'b0 && timeout_err === 1'b0, "R1 flags", 0, 0);
  endtask

  task automatic t_fwd_byte(input logic [DW-1:0] b, input int ack_delay);
    int n;
    tx_data = b; tx_valid = 1'b1;
    wait_level(tx_ready, 1'b1, 20, n);
    chk(tx_ready === 1'b1, "R2 ready in idle", tx_ready, 1);
    @(negedge clk); tx_valid = 1'b0;
    n = 1;
    while (host_clk_n === 1'b1 && n < 50) begin @(negedge clk); n++; end
    chk(n == SETUP + 1, "R3 setup cycles", n, SETUP + 1);
    chk(pd_out === b && pd_oe === 1'b1, "R3 data on bus", pd_out, b);
    repeat (ack_delay) @(negedge clk);
    chk(host_clk_n === 1'b0 && pd_out === b, "R4 strobe held", host_clk_n, 0);
    periph_ack = 1'b1;
    wait_level(host_clk_n, 1'b1, 10, n);
    chk(host_clk_n === 1'b1, "R4 strobe release", host_clk_n, 1);
    repeat (4) @(negedge clk);
    chk(tx_ready === 1'b0, "R5 not done while ack high", tx_ready, 0);
    periph_ack = 1'b0;
    wait_level(tx_ready, 1'b1, 10, n);
    chk(tx_ready === 1'b1, "R5 done after ack low", tx_ready, 1);
  endtask

  task automatic t_busy_blocks();
    periph_ack = 1'b1;
    repeat (4) @(negedge clk);
    tx_data = 8'h3C; tx_valid = 1'b1;
    repeat (8) @(negedge clk);
    chk(host_clk_n === 1'b1 && tx_ready === 1'b0, "R2 busy blocks start", tx_ready, 0);
    tx_valid = 1'b0; periph_ack = 1'b0;
    repeat (4) @(negedge clk);
    t_fwd_byte(8'h3C, 2);
  endtask

  task automatic t_req_in_flight();
    int n;
    periph_req_n = 1'b0;
    t_fwd_byte(8'hA5, 1);
    chk(periph_req === 1'b1, "R6 request flagged forward", periph_req, 1);
  endtask

  task automatic t_enter_reverse();
    int n;
    tx_data = 8'h77; tx_valid = 1'b1; rev_req = 1'b1;
    #1;
    chk(tx_ready === 1'b0, "R2 reverse wins over tx", tx_ready, 0);
    wait_level(pd_oe, 1'b0, 10, n);
    chk(pd_oe === 1'b0 && host_ack === 1'b0, "R7 reverse idle", host_ack, 0);
    repeat (4) @(negedge clk);
    chk(host_clk_n === 1'b1, "R2 no byte sent", host_clk_n, 1);
    chk(periph_req === 1'b0, "R6 flag low in reverse", periph_req, 0);
    tx_valid = 1'b0; periph_req_n = 1'b1;
  endtask

  task automatic t_rev_byte(input logic [DW-1:0] b);
    int n;
    pd_in = b; periph_clk = 1'b0;
    wait_level(host_ack, 1'b1, 10, n);
    chk(host_ack === 1'b1, "R8 ack raised", host_ack, 1);
    periph_clk = 1'b1;
    wait_level(rx_valid, 1'b1, 10, n);
    chk(rx_data === b, "R9 byte captured", rx_data, b);
    chk(host_ack === 1'b0, "R9 ack low after byte", host_ack, 0);
  endtask

  task automatic t_backpressure_and_turn();
    int n;
    t_rev_byte(8'h5A);
    pd_in = 8'hC3; periph_clk = 1'b0;
    repeat (8) @(negedge clk);
    chk(host_ack === 1'b0, "R8 slot full holds ack", host_ack, 0);
    chk(rx_valid === 1'b1 && rx_data === 8'h5A, "R9 byte held", rx_data, 8'h5A);
    rx_ready = 1'b1; @(negedge clk); rx_ready = 1'b0;
    wait_level(host_ack, 1'b1, 10, n);
    chk(host_ack === 1'b1, "R8 ack after drain", host_ack, 1);
    rev_req = 1'b0;
    repeat (6) @(negedge clk);
    chk(pd_oe === 1'b0, "R7 no turn mid byte", pd_oe, 0);
    periph_clk = 1'b1;
    wait_level(rx_valid, 1'b1, 10, n);
    chk(rx_data === 8'hC3, "R9 second byte", rx_data, 8'hC3);
    rx_ready = 1'b1; @(negedge clk); rx_ready = 1'b0;
    wait_level(pd_oe, 1'b1, 10, n);
    chk(pd_oe === 1'b1 && host_ack === 1'b1, "R7 back to forward", pd_oe, 1);
  endtask

  task automatic t_timeout();
    int n;
    tx_data = 8'hE1; tx_valid = 1'b1;
    wait_level(tx_ready, 1'b1, 20, n);
    @(negedge clk); tx_valid = 1'b0;
    wait_level(host_clk_n, 1'b0, 20, n);
    chk(timeout_err === 1'b0, "R10 no error yet", timeout_err, 0);
    n = 0;
    while (host_clk_n === 1'b0 && n < TMO + 20) begin @(negedge clk); n++; end
    chk(n == TMO, "R10 abort cycle", n, TMO);
    chk(timeout_err === 1'b1, "R10 error set", timeout_err, 1);
    t_fwd_byte(8'h0F, 1);
    chk(timeout_err === 1'b1, "R10 error sticky", timeout_err, 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    repeat (3) @(negedge clk);
    t_fwd_byte(8'h96, 3);
    t_busy_blocks();
    t_req_in_flight();
    t_enter_reverse();
    t_backpressure_and_turn();
    t_timeout();
    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule